// File: doc/BRIEF.md
# Broadcast resource state controller

This block holds the operating state of a set of power resources (28 by default) and updates them from 16-bit control messages. Each resource has its own configuration. That configuration consists of a mask of three processor groups, a primary type, a secondary type, and two remap nibbles. One nibble translates a sleep request and the other translates an off request into the state that the resource actually takes.

A message either targets one resource by its index or is broadcast. A broadcast reaches every resource whose group mask overlaps the message's group bits and whose two type fields match the message, with wildcards allowed. Configuration is written one field group at a time through a small write port. The current state of every resource is visible at all times on a flat output vector, four bits per resource, with resource 0 in the low bits.

Top module: `rsc_ctrl`

## Requirements
- R1: After reset every resource state is 0 (off). Every configuration is at its default: group mask 3'b111, type 0, secondary type 0, sleep remap 8 and off remap 0.
- R2: When `msg_v_i` is high and bit 15 of `msg_i` is 0, the message is singular. It addresses only the resource whose index equals `msg_i[8:4]`, and the new state appears one clock later. An index of `N_RES` or above changes nothing.
- R3: When bit 15 of `msg_i` is 1, the message is a broadcast with group bits `[14:12]`, type `[11:9]` and secondary type `[8:7]`. A resource is hit when its group mask ANDed with the message group is non-zero, its type equals the message type or the message type is 7, and its secondary type equals the message's or the message's is 3.
- R4: The requested state sits in `msg_i[3:0]`. A sleep request (8) sets a hit resource to its sleep remap nibble, and an off request (0) sets it to its off remap nibble.
- R5: An active request (9) sets a hit resource to 9 without remapping.
- R6: A warm-reset request (15) sets a hit resource to 9 and restores its whole configuration to the defaults of R1.
- R7: A message whose state code is not 0, 8, 9 or 15 changes no state.
- R8: A write with `cfg_we_i` high updates resource `cfg_res_i` according to `cfg_sel_i`. Select 0 takes the group mask from `cfg_data_i[7:5]`. Select 1 takes the type from `[2:0]` and the secondary type from `[4:3]`. Select 2 takes the sleep remap from `[3:0]` and the off remap from `[7:4]`. Select 3, and any index of `N_RES` or above, changes nothing.
- R9: A message and a configuration write in the same cycle are both applied. The message is evaluated against the configuration held before the write. When a warm reset and a write hit the same resource, the written field replaces the restored default.
- R10: While `msg_v_i` is low no state changes, whatever `msg_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_v_i | input | 1 | Message strobe |
| msg_i | input | 16 | Message word |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_res_i | input | 5 | Resource index of the write |
| cfg_sel_i | input | 2 | Field group of the write |
| cfg_data_i | input | 8 | Write data |
| state_o | output | 4*N_RES | Current state per resource, resource 0 at bits 3:0 |

## Verification
A configuration write and a message can land on the same resource in the same cycle. The message has to see the old remap, while the write must still take effect. A warm reset competes with a write for the same configuration fields. The bench provokes both cases on purpose: it remaps a resource and sends it a sleep request in the same cycle, then sends a warm reset alongside a remap write. It judges the result from the state after that message and from the state after a following sleep request. A long random phase mixes writes and messages freely, so that these collisions also occur by chance. A behavioural model that applies messages before writes is compared against the design every cycle.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int ST_W  = 4;
  localparam int IDX_W = 5;

  typedef logic [ST_W-1:0] st_t;

  localparam st_t ST_OFF    = 4'd0;
  localparam st_t ST_SLEEP  = 4'd8;
  localparam st_t ST_ACTIVE = 4'd9;
  localparam st_t ST_WRST   = 4'd15;

  localparam logic [2:0] TYPE_ANY  = 3'd7;
  localparam logic [1:0] TYPE2_ANY = 2'd3;

  typedef enum logic [1:0] {
    SEL_GRP   = 2'd0,
    SEL_TYPE  = 2'd1,
    SEL_REMAP = 2'd2,
    SEL_SPARE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [2:0] grp;
    logic [2:0] typ;
    logic [1:0] typ2;
    st_t        rmp_off;
    st_t        rmp_slp;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{grp: 3'b111, typ: 3'd0, typ2: 2'd0,
                                   rmp_off: ST_OFF, rmp_slp: ST_SLEEP};

  typedef struct packed {
    logic             bcast;
    logic [IDX_W-1:0] id;
    logic [2:0]       grp;
    logic [2:0]       typ;
    logic [1:0]       typ2;
    st_t              req;
    logic             known;
  } msg_t;
endpackage

// File: rtl/rsc_msg_decode.sv
module rsc_msg_decode
  import rsc_pkg::*;
(
  input  logic [15:0] msg_i,
  output msg_t        dec_o
);
  always_comb begin
    dec_o.bcast = msg_i[15];
    dec_o.grp   = msg_i[14:12];
    dec_o.typ   = msg_i[11:9];
    dec_o.typ2  = msg_i[8:7];
    dec_o.id    = msg_i[8:4];
    dec_o.req   = msg_i[3:0];
    dec_o.known = (msg_i[3:0] == ST_OFF) || (msg_i[3:0] == ST_SLEEP) ||
                  (msg_i[3:0] == ST_ACTIVE) || (msg_i[3:0] == ST_WRST);
  end
endmodule

// File: rtl/rsc_slot.sv
module rsc_slot
  import rsc_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       msg_v_i,
  input  msg_t       dec_i,
  input  logic       wr_hit_i,
  input  logic [1:0] cfg_sel_i,
  input  logic [7:0] cfg_data_i,
  output st_t        st_o,
  output logic       hit_o
);
  cfg_t cfg_q;
  st_t  st_q;
  st_t  st_nxt;
  logic bc_match;

  assign bc_match = ((cfg_q.grp & dec_i.grp) != 3'b000) &&
                    ((dec_i.typ == TYPE_ANY) || (dec_i.typ == cfg_q.typ)) &&
                    ((dec_i.typ2 == TYPE2_ANY) || (dec_i.typ2 == cfg_q.typ2));

  assign hit_o = msg_v_i && dec_i.known &&
                 (dec_i.bcast ? bc_match : (dec_i.id == IDX_W'(IDX)));

  always_comb begin
    unique case (dec_i.req)
      ST_SLEEP: st_nxt = cfg_q.rmp_slp;
      ST_OFF:   st_nxt = cfg_q.rmp_off;
      default:  st_nxt = ST_ACTIVE;   // active and warm reset
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_DEFAULT;
      st_q  <= ST_OFF;
    end else begin
      if (hit_o) st_q <= st_nxt;
      if (hit_o && dec_i.req == ST_WRST) cfg_q <= CFG_DEFAULT;
      // write after restore: the written field wins
      if (wr_hit_i) begin
        case (cfg_sel_e'(cfg_sel_i))
          SEL_GRP:   cfg_q.grp <= cfg_data_i[7:5];
          SEL_TYPE: begin
            cfg_q.typ  <= cfg_data_i[2:0];
            cfg_q.typ2 <= cfg_data_i[4:3];
          end
          SEL_REMAP: begin
            cfg_q.rmp_slp <= cfg_data_i[3:0];
            cfg_q.rmp_off <= cfg_data_i[7:4];
          end
          default: ;
        endcase
      end
    end
  end

  assign st_o = st_q;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_v_i |=> $stable(st_q));
  assert_unknown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_v_i && !dec_i.known) |=> $stable(st_q));
  assert_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && dec_i.req == ST_ACTIVE) |=> st_q == ST_ACTIVE);
  assert_wrst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && dec_i.req == ST_WRST) |=> st_q == ST_ACTIVE);
  assert_sleep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && dec_i.req == ST_SLEEP) |=> st_q == $past(cfg_q.rmp_slp));
  assert_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && dec_i.req == ST_OFF) |=> st_q == $past(cfg_q.rmp_off));
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int N_RES = 28
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  msg_v_i,
  input  logic [15:0]           msg_i,
  input  logic                  cfg_we_i,
  input  logic [IDX_W-1:0]      cfg_res_i,
  input  logic [1:0]            cfg_sel_i,
  input  logic [7:0]            cfg_data_i,
  output logic [N_RES*ST_W-1:0] state_o
);
  msg_t             dec;
  logic [N_RES-1:0] hit_vec;

  rsc_msg_decode u_dec (
    .msg_i (msg_i),
    .dec_o (dec)
  );

  for (genvar g = 0; g < N_RES; g++) begin : g_slot
    logic wr_hit;
    assign wr_hit = cfg_we_i && (cfg_res_i == IDX_W'(g));

    rsc_slot #(.IDX(g)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .msg_v_i    (msg_v_i),
      .dec_i      (dec),
      .wr_hit_i   (wr_hit),
      .cfg_sel_i  (cfg_sel_i),
      .cfg_data_i (cfg_data_i),
      .st_o       (state_o[g*ST_W +: ST_W]),
      .hit_o      (hit_vec[g])
    );
  end

  assert_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_v_i && !msg_i[15]) |-> $onehot0(hit_vec));
  assert_no_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_v_i |-> (hit_vec == '0));
endmodule

// File: tb/rsc_ctrl_tb.sv
module rsc_ctrl_tb;
  localparam int N = 28;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          msg_v = 1'b0;
  logic [15:0]   msg = '0;
  logic          we = 1'b0;
  logic [4:0]    res = '0;
  logic [1:0]    sel = '0;
  logic [7:0]    data = '0;
  logic [N*4-1:0] state;

  always #2 clk = ~clk;

  rsc_ctrl #(.N_RES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .msg_v_i(msg_v), .msg_i(msg),
    .cfg_we_i(we), .cfg_res_i(res), .cfg_sel_i(sel), .cfg_data_i(data),
    .state_o(state)
  );

  int m_grp[N], m_typ[N], m_typ2[N], m_rs[N], m_ro[N], m_st[N];
  int checks = 0, fails = 0;

  function automatic logic [15:0] sing(int id, int st);
    return {1'b0, 6'd0, 5'(id), 4'(st)};
  endfunction

  function automatic logic [15:0] bc(int g, int t, int t2, int st);
    return {1'b1, 3'(g), 3'(t), 2'(t2), 3'd0, 4'(st)};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_grp[i] = 7; m_typ[i] = 0; m_typ2[i] = 0;
      m_rs[i] = 8; m_ro[i] = 0; m_st[i] = 0;
    end
  endtask

  task automatic model_step();
    int nst[N];
    int rq, b, mg, mt, mt2, id;
    bit hit;
    for (int i = 0; i < N; i++) nst[i] = m_st[i];
    rq = int'(msg[3:0]); b = int'(msg[15]); mg = int'(msg[14:12]);
    mt = int'(msg[11:9]); mt2 = int'(msg[8:7]); id = int'(msg[8:4]);
    if (msg_v && (rq == 0 || rq == 8 || rq == 9 || rq == 15)) begin
      for (int i = 0; i < N; i++) begin
        if (b == 1)
          hit = ((m_grp[i] & mg) != 0) && (mt == 7 || mt == m_typ[i]) &&
                (mt2 == 3 || mt2 == m_typ2[i]);
        else
          hit = (id == i);
        if (hit) begin
          nst[i] = (rq == 8) ? m_rs[i] : (rq == 0) ? m_ro[i] : 9;
          if (rq == 15) begin
            m_grp[i] = 7; m_typ[i] = 0; m_typ2[i] = 0; m_rs[i] = 8; m_ro[i] = 0;
          end
        end
      end
    end
    if (we && int'(res) < N) begin
      case (sel)
        2'd0: m_grp[res] = int'(data[7:5]);
        2'd1: begin m_typ[res] = int'(data[2:0]); m_typ2[res] = int'(data[4:3]); end
        2'd2: begin m_rs[res] = int'(data[3:0]); m_ro[res] = int'(data[7:4]); end
        default: ;
      endcase
    end
    for (int i = 0; i < N; i++) m_st[i] = nst[i];
  endtask

  task automatic check(string tag);
    logic [N*4-1:0] exp;
    for (int i = 0; i < N; i++) exp[i*4 +: 4] = 4'(m_st[i]);
    checks++;
    if (state !== exp) begin
      fails++;
      $display("FAIL %s: state_o=%h expected %h", tag, state, exp);
    end
  endtask

  // called at a negedge; compares at the following negedge
  task automatic step(string tag, logic mv, logic [15:0] m,
                      logic w, int r, int s, int d);
    msg_v = mv; msg = m; we = w; res = 5'(r); sel = 2'(s); data = 8'(d);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release");

    step("R2 R5 singular active id 3", 1, sing(3, 9), 0, 0, 0, 0);
    step("R2 singular id out of range", 1, sing(30, 9), 0, 0, 0, 0);
    step("R3 R5 broadcast active all", 1, bc(7, 7, 3, 9), 0, 0, 0, 0);
    step("R8 remap write res 5", 0, 16'h0, 1, 5, 2, 8'h80);
    step("R4 broadcast sleep", 1, bc(7, 7, 3, 8), 0, 0, 0, 0);
    step("R4 broadcast off", 1, bc(7, 7, 3, 0), 0, 0, 0, 0);
    step("R8 group write res 2", 0, 16'h0, 1, 2, 0, 8'h80);
    step("R8 type write res 2", 0, 16'h0, 1, 2, 1, 8'h0B);
    step("R3 group mismatch skips res 2", 1, bc(1, 7, 3, 9), 0, 0, 0, 0);
    step("R3 exact type match res 2", 1, bc(4, 3, 1, 8), 0, 0, 0, 0);
    step("R3 secondary type mismatch", 1, bc(4, 3, 2, 0), 0, 0, 0, 0);
    step("R3 type mismatch", 1, bc(7, 2, 3, 0), 0, 0, 0, 0);
    step("R8 spare select ignored", 0, 16'h0, 1, 4, 3, 8'hFF);
    step("R8 index out of range ignored", 0, 16'h0, 1, 29, 2, 8'h11);
    step("R8 spare write no effect on sleep", 1, bc(7, 7, 3, 8), 0, 0, 0, 0);
    step("R7 unknown code", 1, sing(4, 5), 0, 0, 0, 0);
    step("R7 unknown broadcast code", 1, bc(7, 7, 3, 3), 0, 0, 0, 0);
    step("R6 warm reset res 5", 1, sing(5, 15), 0, 0, 0, 0);
    step("R6 defaults after warm reset", 1, sing(5, 0), 0, 0, 0, 0);
    step("R9 write and sleep same cycle", 1, sing(7, 8), 1, 7, 2, 8'h00);
    step("R9 new remap then applies", 1, sing(7, 8), 0, 0, 0, 0);
    step("R9 warm reset with write", 1, sing(7, 15), 1, 7, 2, 8'h21);
    step("R9 written field beats default", 1, sing(7, 8), 0, 0, 0, 0);
    step("R9 written off remap", 1, sing(7, 0), 0, 0, 0, 0);
    step("R10 no strobe holds", 0, bc(7, 7, 3, 9), 0, 0, 0, 0);
    step("R10 no strobe holds singular", 0, sing(0, 9), 0, 0, 0, 0);

    for (int k = 0; k < 400; k++) begin
      int pick, st;
      pick = int'($urandom_range(0, 4));
      st = (pick == 0) ? 0 : (pick == 1) ? 8 : (pick == 2) ? 9 :
           (pick == 3) ? 15 : int'($urandom_range(0, 15));
      step("R2 R3 R4 R9 random mix", ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 1) == 1) ?
             bc(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                int'($urandom_range(0, 3)), st) :
             sing(int'($urandom_range(0, 31)), st),
           ($urandom_range(0, 1) == 1), int'($urandom_range(0, 31)),
           int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
    end

    msg_v = 0; we = 0;
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule